// File: doc/BRIEF.md
# Execute and Next-PC Unit

This block is the combinational execute step of a small 32-bit load/store processor. Each cycle it takes the already-decoded instruction fields, the two source register values and the current program counter. It returns the values the rest of the core needs to update its state: the instruction class, the destination register, one data word and one address. It also returns a flag that says whether the control-flow condition holds.

The block contains three parts: an ALU, a branch condition evaluator and a next-PC calculator. Both result ports are shared between instruction classes.

- The data word is the ALU result, the store data or the link address PC+4.
- The address is the memory address for loads and stores, and the next fetch address for every other class.

The register file, the memories and the decoder sit outside this block. The block has no clock and holds no state.

Top module: `exu_unit`

## Requirements
- R1: The second ALU operand is `i_imm` when `i_imm_vld` is 1, and `i_rs2_val` when it is 0.
- R2: ALU op codes 0..5 give add, subtract (a-b), AND, OR, XOR and NOR of the two operands. Add and subtract wrap modulo 2^32.
- R3: ALU op 6 gives 1 when operand a is less than operand b as signed values, and 0 otherwise. Op 7 does the same compare as unsigned values.
- R4: ALU ops 8, 9 and 10 shift operand a. Op 8 shifts left, op 9 shifts right with zero fill, and op 10 shifts right with sign fill. The shift amount is the low 5 bits of operand b.
- R5: The data output is `i_rs2_val` for class 3 (store). It is PC+4 for class 4 (jump) and class 5 (register jump). It is the ALU result for every other class.
- R6: Condition code 0 is true when the two register values are equal. Code 1 is true when they differ.
- R7: Codes 2..5 test `i_rs1_val` as a signed value against zero: code 2 is <=0, code 3 is <0, code 4 is >=0 and code 5 is >0. Code 6 is always true and code 7 is always false. `o_taken` shows the condition result for every class.
- R8: For class 4 (jump), the address is the top 4 bits of PC+4 followed by the low 28 bits of `i_imm`.
- R9: For class 5 (register jump), the address is `i_rs1_val`.
- R10: For class 6 (branch), the address is PC+4+imm when the condition holds, and PC+4 when it does not. Classes 0 (unsupported) and 1 (ALU) give PC+4 whatever the condition is.
- R11: For class 2 (load) and class 3 (store), the address is the ALU result.
- R12: `o_cls`, `o_dst_vld` and `o_dst_idx` repeat the matching inputs unchanged.
- R13: ALU op codes 11..15 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_cls | input | 3 | Instruction class: 0 unsupported, 1 ALU, 2 load, 3 store, 4 jump, 5 register jump, 6 branch |
| i_alu_op | input | 4 | ALU operation code |
| i_cmp_op | input | 3 | Branch condition code |
| i_dst_vld | input | 1 | Destination register present |
| i_dst_idx | input | 5 | Destination register index |
| i_imm_vld | input | 1 | Immediate present |
| i_imm | input | 32 | Extended immediate |
| i_rs1_val | input | 32 | First register value |
| i_rs2_val | input | 32 | Second register value |
| i_pc | input | 32 | Address of the current instruction |
| o_cls | output | 3 | Class, passed through |
| o_dst_vld | output | 1 | Destination present, passed through |
| o_dst_idx | output | 5 | Destination index, passed through |
| o_data | output | 32 | ALU result, store data or link address |
| o_addr | output | 32 | Memory address or next fetch address |
| o_taken | output | 1 | Condition result |

## Verification
The ALU is driven with operand pairs that separate the operations from each other:

- Overlapping bit masks give a different result for AND, OR, XOR and NOR.
- An all-ones value against 1 gives different answers for the signed and unsigned compares.
- A shift count above 31 shows that only its low 5 bits are used.
- A most-significant-bit-set value shows the difference between logical and arithmetic right shifts.

The signed zero tests use the values zero, one and the most negative number, which tell <=, <, >= and > apart. Branch vectors use positive and negative offsets, and each is run with the condition true and with it false. A jump from a PC with non-zero top bits checks how the target is assembled. An always-true condition on an ALU instruction checks that the address stays PC+4 for that class.

// File: rtl/exu_pkg.sv
package exu_pkg;

   localparam int CLS_W = 3;
   localparam int ALU_W = 4;
   localparam int CMP_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_BAD    = 3'd0,
      CLS_ALU    = 3'd1,
      CLS_LOAD   = 3'd2,
      CLS_STORE  = 3'd3,
      CLS_JUMP   = 3'd4,
      CLS_JREG   = 3'd5,
      CLS_BRANCH = 3'd6
   } exu_cls_e;

   typedef enum logic [ALU_W-1:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_AND  = 4'd2,
      ALU_OR   = 4'd3,
      ALU_XOR  = 4'd4,
      ALU_NOR  = 4'd5,
      ALU_SLT  = 4'd6,
      ALU_SLTU = 4'd7,
      ALU_SLL  = 4'd8,
      ALU_SRL  = 4'd9,
      ALU_SRA  = 4'd10
   } exu_alu_e;

   typedef enum logic [CMP_W-1:0] {
      CMP_EQ    = 3'd0,
      CMP_NE    = 3'd1,
      CMP_LEZ   = 3'd2,
      CMP_LTZ   = 3'd3,
      CMP_GEZ   = 3'd4,
      CMP_GTZ   = 3'd5,
      CMP_ALWAYS = 3'd6,
      CMP_NEVER = 3'd7
   } exu_cmp_e;

endpackage

// File: rtl/exu_alu.sv
module exu_alu
   import exu_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit BARREL_SHIFT = 1'b1
) (
   input  logic [ALU_W-1:0] op,
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   output logic [XLEN-1:0]  res
);

   localparam int SHAMT_W = $clog2(XLEN);

   if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("exu_alu: XLEN must be a power of two, at least 8");
   end

   logic [SHAMT_W-1:0] shamt;
   logic [XLEN-1:0]    sh_left;
   logic [XLEN-1:0]    sh_rlog;
   logic [XLEN-1:0]    sh_rari;

   assign shamt = b[SHAMT_W-1:0];

   if (BARREL_SHIFT) begin : g_barrel
      logic [XLEN-1:0] l_st [0:SHAMT_W];
      logic [XLEN-1:0] z_st [0:SHAMT_W];
      logic [XLEN-1:0] s_st [0:SHAMT_W];
      assign l_st[0] = a;
      assign z_st[0] = a;
      assign s_st[0] = a;
      for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
         localparam int SH = 1 << s;
         assign l_st[s+1] = shamt[s] ? {l_st[s][XLEN-1-SH:0], {SH{1'b0}}} : l_st[s];
         assign z_st[s+1] = shamt[s] ? {{SH{1'b0}}, z_st[s][XLEN-1:SH]} : z_st[s];
         assign s_st[s+1] = shamt[s] ? {{SH{a[XLEN-1]}}, s_st[s][XLEN-1:SH]} : s_st[s];
      end
      assign sh_left = l_st[SHAMT_W];
      assign sh_rlog = z_st[SHAMT_W];
      assign sh_rari = s_st[SHAMT_W];
   end else begin : g_operator
      assign sh_left = a << shamt;
      assign sh_rlog = a >> shamt;
      assign sh_rari = XLEN'($signed(a) >>> shamt);
   end

   always_comb begin
      case (op)
         ALU_ADD:  res = a + b;
         ALU_SUB:  res = a - b;
         ALU_AND:  res = a & b;
         ALU_OR:   res = a | b;
         ALU_XOR:  res = a ^ b;
         ALU_NOR:  res = ~(a | b);
         ALU_SLT:  res = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         ALU_SLTU: res = {{(XLEN-1){1'b0}}, (a < b)};
         ALU_SLL:  res = sh_left;
         ALU_SRL:  res = sh_rlog;
         ALU_SRA:  res = sh_rari;
         default:  res = '0;
      endcase
   end

   always_comb begin
      assert_setflag_width_R3: assert (!(op == ALU_SLT || op == ALU_SLTU) || res[XLEN-1:1] == '0)
         else $error("compare result wider than one bit");
      assert_sub_inverse_R2: assert (op != ALU_SUB || (res + b) == a)
         else $error("subtract result does not invert");
      assert_sra_fill_R4: assert (op != ALU_SRA || shamt == '0 || res[XLEN-1] == a[XLEN-1])
         else $error("arithmetic shift lost sign");
      assert_undef_zero_R13: assert (op <= ALU_SRA || res == '0)
         else $error("undefined op not zero");
   end

endmodule

// File: rtl/exu_brcmp.sv
module exu_brcmp
   import exu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [CMP_W-1:0] op,
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   output logic             taken
);

   logic same, neg, zero;

   assign same = (a == b);
   assign neg  = a[XLEN-1];
   assign zero = (a == '0);

   always_comb begin
      case (op)
         CMP_EQ:     taken = same;
         CMP_NE:     taken = !same;
         CMP_LEZ:    taken = neg || zero;
         CMP_LTZ:    taken = neg;
         CMP_GEZ:    taken = !neg;
         CMP_GTZ:    taken = !neg && !zero;
         CMP_ALWAYS: taken = 1'b1;
         default:    taken = 1'b0;
      endcase
   end

   always_comb begin
      assert_zero_tests_R7: assert (!(op == CMP_GEZ || op == CMP_GTZ) || !taken || !a[XLEN-1])
         else $error("non-negative test taken on negative value");
      assert_eq_match_R6: assert (op != CMP_EQ || !taken || (a ^ b) == '0)
         else $error("equality taken with differing values");
   end

endmodule

// File: rtl/exu_target.sv
module exu_target
   import exu_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int PC_HI_W = 4
) (
   input  logic [CLS_W-1:0] cls,
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  rs1,
   input  logic [XLEN-1:0]  imm,
   input  logic             cond,
   output logic [XLEN-1:0]  pc_plus4,
   output logic [XLEN-1:0]  target
);

   localparam int LO_W = XLEN - PC_HI_W;

   if (PC_HI_W < 1 || PC_HI_W >= XLEN) begin : g_bad_hi
      $error("exu_target: PC_HI_W out of range");
   end

   logic [XLEN-1:0] br_dest;

   assign pc_plus4 = pc + XLEN'(4);
   assign br_dest  = pc_plus4 + imm;

   always_comb begin
      case (cls)
         CLS_JUMP:   target = {pc_plus4[XLEN-1:LO_W], imm[LO_W-1:0]};
         CLS_JREG:   target = rs1;
         CLS_BRANCH: target = cond ? br_dest : pc_plus4;
         default:    target = pc_plus4;
      endcase
   end

   always_comb begin
      assert_jump_low_R8: assert (cls != CLS_JUMP || target[LO_W-1:0] == imm[LO_W-1:0])
         else $error("jump target low bits wrong");
      assert_fallthrough_R10: assert ((cls == CLS_BRANCH && cond) || cls == CLS_JUMP || cls == CLS_JREG
                                      || target - pc == XLEN'(4))
         else $error("fall-through not sequential");
   end

endmodule

// File: rtl/exu_unit.sv
module exu_unit
   import exu_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int REG_IDX_W    = 5,
   parameter int PC_HI_W      = 4,
   parameter bit BARREL_SHIFT = 1'b1
) (
   input  logic [2:0]           i_cls,
   input  logic [3:0]           i_alu_op,
   input  logic [2:0]           i_cmp_op,
   input  logic                 i_dst_vld,
   input  logic [REG_IDX_W-1:0] i_dst_idx,
   input  logic                 i_imm_vld,
   input  logic [XLEN-1:0]      i_imm,
   input  logic [XLEN-1:0]      i_rs1_val,
   input  logic [XLEN-1:0]      i_rs2_val,
   input  logic [XLEN-1:0]      i_pc,
   output logic [2:0]           o_cls,
   output logic                 o_dst_vld,
   output logic [REG_IDX_W-1:0] o_dst_idx,
   output logic [XLEN-1:0]      o_data,
   output logic [XLEN-1:0]      o_addr,
   output logic                 o_taken
);

   if (REG_IDX_W < 1) begin : g_bad_idx
      $error("exu_unit: REG_IDX_W must be positive");
   end

   logic [XLEN-1:0] opnd_b;
   logic [XLEN-1:0] alu_res;
   logic [XLEN-1:0] pc_plus4;
   logic [XLEN-1:0] flow_tgt;
   logic            cond;
   logic            is_mem;

   assign opnd_b = i_imm_vld ? i_imm : i_rs2_val;

   exu_alu #(.XLEN(XLEN), .BARREL_SHIFT(BARREL_SHIFT)) u_alu (
      .op  (i_alu_op),
      .a   (i_rs1_val),
      .b   (opnd_b),
      .res (alu_res)
   );

   exu_brcmp #(.XLEN(XLEN)) u_cmp (
      .op    (i_cmp_op),
      .a     (i_rs1_val),
      .b     (i_rs2_val),
      .taken (cond)
   );

   exu_target #(.XLEN(XLEN), .PC_HI_W(PC_HI_W)) u_tgt (
      .cls      (i_cls),
      .pc       (i_pc),
      .rs1      (i_rs1_val),
      .imm      (i_imm),
      .cond     (cond),
      .pc_plus4 (pc_plus4),
      .target   (flow_tgt)
   );

   assign is_mem = (i_cls == CLS_LOAD) || (i_cls == CLS_STORE);

   always_comb begin
      case (i_cls)
         CLS_STORE:          o_data = i_rs2_val;
         CLS_JUMP, CLS_JREG: o_data = pc_plus4;
         default:            o_data = alu_res;
      endcase
   end

   assign o_addr    = is_mem ? alu_res : flow_tgt;
   assign o_taken   = cond;
   assign o_cls     = i_cls;
   assign o_dst_vld = i_dst_vld;
   assign o_dst_idx = i_dst_idx;

   always_comb begin
      assert_mem_addr_R11: assert (!is_mem || o_addr == alu_res)
         else $error("memory address not from ALU");
      assert_store_data_R5: assert (i_cls != CLS_STORE || o_data == i_rs2_val)
         else $error("store data not second register");
      assert_link_R5: assert (!(i_cls == CLS_JUMP || i_cls == CLS_JREG) || o_data - i_pc == XLEN'(4))
         else $error("link value not PC+4");
      assert_jreg_R9: assert (i_cls != CLS_JREG || o_addr == i_rs1_val)
         else $error("register jump target wrong");
   end

endmodule

// File: tb/exu_unit_tb.sv
module exu_unit_tb;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [2:0]  i_cls, o_cls;
   logic [3:0]  i_alu_op;
   logic [2:0]  i_cmp_op;
   logic        i_dst_vld, o_dst_vld, i_imm_vld, o_taken;
   logic [4:0]  i_dst_idx, o_dst_idx;
   logic [31:0] i_imm, i_rs1_val, i_rs2_val, i_pc, o_data, o_addr;

   exu_unit u_dut (
      .i_cls(i_cls), .i_alu_op(i_alu_op), .i_cmp_op(i_cmp_op),
      .i_dst_vld(i_dst_vld), .i_dst_idx(i_dst_idx),
      .i_imm_vld(i_imm_vld), .i_imm(i_imm),
      .i_rs1_val(i_rs1_val), .i_rs2_val(i_rs2_val), .i_pc(i_pc),
      .o_cls(o_cls), .o_dst_vld(o_dst_vld), .o_dst_idx(o_dst_idx),
      .o_data(o_data), .o_addr(o_addr), .o_taken(o_taken)
   );

   typedef struct packed {
      logic [2:0]  cls;
      logic [3:0]  alu;
      logic [2:0]  cmp;
      logic        immv;
      logic [31:0] imm;
      logic [31:0] rs1;
      logic [31:0] rs2;
      logic [31:0] pc;
      logic [31:0] edata;
      logic [31:0] eaddr;
      logic        etaken;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 4'd0, 3'd7, 1'b0, 32'h0, 32'h5, 32'h7, 32'h100, 32'hC, 32'h104, 1'b0, 4'd2},               // R2 add
      '{3'd1, 4'd0, 3'd7, 1'b1, 32'hFFFFFFFF, 32'h5, 32'h7, 32'h100, 32'h4, 32'h104, 1'b0, 4'd1},        // R1 imm
      '{3'd1, 4'd1, 3'd7, 1'b0, 32'h0, 32'h5, 32'h7, 32'h100, 32'hFFFFFFFE, 32'h104, 1'b0, 4'd2},        // R2 sub
      '{3'd1, 4'd2, 3'd7, 1'b0, 32'h0, 32'hF0F0, 32'hFF00, 32'h100, 32'hF000, 32'h104, 1'b0, 4'd2},      // R2 and
      '{3'd1, 4'd3, 3'd7, 1'b0, 32'h0, 32'hF0F0, 32'hFF00, 32'h100, 32'hFFF0, 32'h104, 1'b0, 4'd2},      // R2 or
      '{3'd1, 4'd4, 3'd7, 1'b0, 32'h0, 32'hF0F0, 32'hFF00, 32'h100, 32'h0FF0, 32'h104, 1'b0, 4'd2},      // R2 xor
      '{3'd1, 4'd5, 3'd7, 1'b0, 32'h0, 32'hF0F0, 32'hFF00, 32'h100, 32'hFFFF000F, 32'h104, 1'b0, 4'd2},  // R2 nor
      '{3'd1, 4'd6, 3'd7, 1'b0, 32'h0, 32'hFFFFFFFF, 32'h1, 32'h100, 32'h1, 32'h104, 1'b0, 4'd3},        // R3 slt
      '{3'd1, 4'd7, 3'd7, 1'b0, 32'h0, 32'hFFFFFFFF, 32'h1, 32'h100, 32'h0, 32'h104, 1'b0, 4'd3},        // R3 sltu
      '{3'd1, 4'd8, 3'd7, 1'b0, 32'h0, 32'h1, 32'h24, 32'h100, 32'h10, 32'h104, 1'b0, 4'd4},             // R4 sll low 5 bits
      '{3'd1, 4'd9, 3'd7, 1'b0, 32'h0, 32'h80000000, 32'h4, 32'h100, 32'h08000000, 32'h104, 1'b0, 4'd4}, // R4 srl
      '{3'd1, 4'd10, 3'd7, 1'b0, 32'h0, 32'h80000000, 32'h4, 32'h100, 32'hF8000000, 32'h104, 1'b0, 4'd4},// R4 sra
      '{3'd1, 4'd10, 3'd7, 1'b0, 32'h0, 32'h80000000, 32'h1F, 32'h100, 32'hFFFFFFFF, 32'h104, 1'b0, 4'd4},// R4 sra 31
      '{3'd1, 4'd15, 3'd7, 1'b0, 32'h0, 32'h5, 32'h7, 32'h100, 32'h0, 32'h104, 1'b0, 4'd13},             // R13
      '{3'd1, 4'd11, 3'd7, 1'b0, 32'h0, 32'h5, 32'h7, 32'h100, 32'h0, 32'h104, 1'b0, 4'd13},             // R13
      '{3'd3, 4'd0, 3'd7, 1'b1, 32'h8, 32'h1000, 32'hABCD, 32'h100, 32'hABCD, 32'h1008, 1'b0, 4'd5},     // R5 store
      '{3'd2, 4'd0, 3'd7, 1'b1, 32'hFFFFFFFC, 32'h1000, 32'h0, 32'h100, 32'hFFC, 32'hFFC, 1'b0, 4'd11},  // R11 load
      '{3'd4, 4'd0, 3'd6, 1'b1, 32'h0ABCDEF0, 32'h0, 32'h0, 32'hF0000000, 32'hF0000004, 32'hFABCDEF0, 1'b1, 4'd8}, // R8
      '{3'd5, 4'd0, 3'd6, 1'b0, 32'h0, 32'h2468, 32'h0, 32'h100, 32'h104, 32'h2468, 1'b1, 4'd9},         // R9
      '{3'd6, 4'd0, 3'd0, 1'b1, 32'h20, 32'h3, 32'h3, 32'h100, 32'h23, 32'h124, 1'b1, 4'd10},            // R10 eq taken
      '{3'd6, 4'd0, 3'd1, 1'b1, 32'h20, 32'h3, 32'h3, 32'h100, 32'h23, 32'h104, 1'b0, 4'd10},            // R10 ne not taken
      '{3'd6, 4'd0, 3'd1, 1'b1, 32'hFFFFFFF8, 32'h3, 32'h4, 32'h100, 32'hFFFFFFFB, 32'hFC, 1'b1, 4'd10}, // R10 back
      '{3'd6, 4'd0, 3'd0, 1'b1, 32'h10, 32'h3, 32'h4, 32'h100, 32'h13, 32'h104, 1'b0, 4'd6},             // R6 eq false
      '{3'd6, 4'd0, 3'd2, 1'b1, 32'h10, 32'h0, 32'h0, 32'h100, 32'h10, 32'h114, 1'b1, 4'd7},             // R7 le 0
      '{3'd6, 4'd0, 3'd3, 1'b1, 32'h10, 32'h0, 32'h0, 32'h100, 32'h10, 32'h104, 1'b0, 4'd7},             // R7 lt 0
      '{3'd6, 4'd0, 3'd4, 1'b1, 32'h10, 32'h0, 32'h0, 32'h100, 32'h10, 32'h114, 1'b1, 4'd7},             // R7 ge 0
      '{3'd6, 4'd0, 3'd5, 1'b1, 32'h10, 32'h0, 32'h0, 32'h100, 32'h10, 32'h104, 1'b0, 4'd7},             // R7 gt 0
      '{3'd6, 4'd0, 3'd3, 1'b1, 32'h10, 32'h80000000, 32'h0, 32'h100, 32'h80000010, 32'h114, 1'b1, 4'd7},// R7 lt neg
      '{3'd6, 4'd0, 3'd4, 1'b1, 32'h10, 32'h80000000, 32'h0, 32'h100, 32'h80000010, 32'h104, 1'b0, 4'd7},// R7 ge neg
      '{3'd6, 4'd0, 3'd5, 1'b1, 32'h10, 32'h1, 32'h0, 32'h100, 32'h11, 32'h114, 1'b1, 4'd7},             // R7 gt 1
      '{3'd6, 4'd0, 3'd2, 1'b1, 32'h10, 32'h1, 32'h0, 32'h100, 32'h11, 32'h104, 1'b0, 4'd7},             // R7 le 1
      '{3'd6, 4'd0, 3'd6, 1'b1, 32'h10, 32'h1, 32'h0, 32'h100, 32'h11, 32'h114, 1'b1, 4'd7},             // R7 always
      '{3'd6, 4'd0, 3'd7, 1'b1, 32'h10, 32'h1, 32'h1, 32'h100, 32'h11, 32'h104, 1'b0, 4'd7},             // R7 never
      '{3'd0, 4'd0, 3'd7, 1'b0, 32'h0, 32'h1, 32'h2, 32'h100, 32'h3, 32'h104, 1'b0, 4'd10},              // R10 unsupported
      '{3'd1, 4'd0, 3'd6, 1'b0, 32'h0, 32'h1, 32'h2, 32'h100, 32'h3, 32'h104, 1'b1, 4'd10},              // R10 alu always
      '{3'd6, 4'd0, 3'd1, 1'b0, 32'h0, 32'h1, 32'h2, 32'hFFFFFFFC, 32'h3, 32'h0, 1'b1, 4'd10}            // R10 wrap, imm 0
   };

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(posedge clk);
      i_cls = v.cls; i_alu_op = v.alu; i_cmp_op = v.cmp;
      i_imm_vld = v.immv; i_imm = v.imm;
      i_rs1_val = v.rs1; i_rs2_val = v.rs2; i_pc = v.pc;
      @(negedge clk);
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      i_cls = '0; i_alu_op = '0; i_cmp_op = '0; i_dst_vld = 1'b0; i_dst_idx = '0;
      i_imm_vld = 1'b0; i_imm = '0; i_rs1_val = '0; i_rs2_val = '0; i_pc = '0;
      @(negedge clk);
      // all-zero bundle: equal zeros give taken, address PC+4
      chk("R2 idle data", o_data, 32'h0);
      chk("R10 idle addr", o_addr, 32'h4);
      chk("R6 idle taken", {31'b0, o_taken}, 32'h1);

      for (int k = 0; k < NV; k++) begin
         string tag;
         drive(VECS[k]);
         tag = $sformatf("R%0d vec%0d", VECS[k].rq, k);
         chk({tag, " data"}, o_data, VECS[k].edata);
         chk({tag, " addr"}, o_addr, VECS[k].eaddr);
         chk({tag, " taken"}, {31'b0, o_taken}, {31'b0, VECS[k].etaken});
         chk({"R12 cls ", tag}, {29'b0, o_cls}, {29'b0, VECS[k].cls});
      end

      // R12 destination pass-through under two patterns
      @(posedge clk); i_dst_vld = 1'b1; i_dst_idx = 5'd31; i_cls = 3'd4;
      @(negedge clk);
      chk("R12 dst vld", {31'b0, o_dst_vld}, 32'h1);
      chk("R12 dst idx", {27'b0, o_dst_idx}, 32'd31);
      @(posedge clk); i_dst_vld = 1'b0; i_dst_idx = 5'd10; i_cls = 3'd7;
      @(negedge clk);
      chk("R12 dst vld off", {31'b0, o_dst_vld}, 32'h0);
      chk("R12 dst idx 10", {27'b0, o_dst_idx}, 32'd10);
      chk("R12 cls 7", {29'b0, o_cls}, 32'd7);

      // R1 immediate invalid: rs2 used even when imm is nonzero
      @(posedge clk); i_cls = 3'd1; i_alu_op = 4'd0; i_imm_vld = 1'b0;
      i_imm = 32'h1000; i_rs1_val = 32'h1; i_rs2_val = 32'h2;
      @(negedge clk);
      chk("R1 imm ignored", o_data, 32'h3);

      finish_up();
   end

endmodule